// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between eight serial time-division streams. On every input stream it takes in 32 eight-bit channels per frame, most significant bit first, and stores each byte in a data memory at the address formed from its stream and channel. On every output stream it transmits 32 channels. For each output channel, a connection entry chooses the byte to send. The byte can be a stored input byte, which gives a full switch in which any input channel can reach any output channel. It can be a literal value that the host wrote, which is sent again in every frame. It can also be nothing, in which case the channel idles at all ones, the same level as an undriven line.

The fabric clock runs faster than the line rate. A one-cycle strobe `bit_en` marks each serial bit period, and `frame_pulse` is raised together with the strobe that carries the first bit of a frame. The data memory is double-banked by frame. A byte captured in frame N is therefore transmitted in frame N+1, never earlier and never later. The host writes connection entries through a simple write port. Each entry is read once, at the first bit of its channel.

The frame tracker is a two-state machine:
- SYNC_HUNT: the outputs stay at ones and no bytes are captured. A strobe with the frame pulse moves it to SYNC_RUN and sets the position to 0.
- SYNC_RUN: each strobe advances the bit position by one.
  - A strobe with the frame pulse restarts the frame at position 0 and stays in SYNC_RUN.
  - A strobe without the pulse after the last bit (position 255) drops back to SYNC_HUNT.

Top module: `tsi_switch`

## Requirements
- R1: After reset, and before the first frame pulse, every output bit is 1 and strobes without a pulse change nothing.
- R2: The strobe that carries the frame pulse is position 0, and each later strobe adds one. Position p is channel p/8, and its bit is 7-(p mod 8). Both capture and transmission are MSB first.
- R3: The byte received on input stream s, channel c is stored at data address {s[2:0], c[4:0]}.
- R4: An output channel with drive=1 and literal=0 transmits, in frame N+1, the byte received in frame N on the input stream and channel named by value[7:5] and value[4:0].
- R5: An output channel with drive=1 and literal=1 transmits its 8-bit value in every frame until the entry is rewritten.
- R6: An output channel with drive=0 transmits all ones. All entries are reset to drive=0.
- R7: The host writes entry {stream[2:0], channel[4:0]} on `cm_addr`. The entry is read at bit 0 of its channel. A write made during that channel leaves the byte in progress unchanged and takes effect at the channel's next occurrence.
- R8: A strobe without a pulse that follows position 255 loses sync. All outputs go to ones and stay there until the next frame pulse.
- R9: A frame pulse that arrives before position 255 restarts the frame at channel 0. Byte-to-byte delivery continues into the following frame for every channel completed before the restart.
- R10: Outputs change only at clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per serial bit period |
| frame_pulse | input | 1 | High with the strobe carrying the first bit of a frame |
| ser_in | input | 8 | Serial input streams, one bit per stream |
| ser_out | output | 8 | Serial output streams, one bit per stream |
| cm_we | input | 1 | Connection entry write enable |
| cm_addr | input | 8 | Entry address {stream, channel} |
| cm_drive | input | 1 | Entry output-enable flag |
| cm_literal | input | 1 | Entry message-mode flag |
| cm_value | input | 8 | Source address (switch mode) or literal byte (message mode) |

## Verification
The bench targets the one-frame switching delay. An off-by-one bank choice would send the current frame's byte or a two-frame-old byte. It also checks that capture and transmission are MSB first, because a bit-order error would reverse every switched byte.

Host writes that land in the middle of a channel are compared against a byte latched at bit 0. A design that read the entry on every bit would splice the old and new values together.

A frame cut short by an early pulse is followed by a full frame. Only the channels completed before the restart are expected to pass through, so a design that lost its bank parity on the restart would deliver stale data. A run of strobes past position 255 without a pulse must force ones onto every line; a free-running counter would keep transmitting.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int unsigned STREAMS  = 8;
    localparam int unsigned CHANNELS = 32;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned STR_W    = $clog2(STREAMS);
    localparam int unsigned CH_W     = $clog2(CHANNELS);
    localparam int unsigned BIT_W    = $clog2(BYTE_W);
    localparam int unsigned POS_W    = CH_W + BIT_W;
    localparam int unsigned ADDR_W   = STR_W + CH_W;
    localparam int unsigned SLOTS    = STREAMS * CHANNELS;

    typedef enum logic {
        SYNC_HUNT = 1'b0,
        SYNC_RUN  = 1'b1
    } sync_state_e;

    typedef struct packed {
        logic              drive;
        logic              literal;
        logic [BYTE_W-1:0] value;
    } conn_entry_t;
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             frame_pulse,
    output logic             act,
    output logic [POS_W-1:0] pos,
    output logic             bank
);
    localparam logic [POS_W-1:0] LAST_POS = '1;

    sync_state_e      state_q, state_d;
    logic [POS_W-1:0] cnt_q;
    logic             bank_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_HUNT: if (bit_en && frame_pulse) state_d = SYNC_RUN;
            SYNC_RUN:  if (bit_en && !frame_pulse && cnt_q == LAST_POS) state_d = SYNC_HUNT;
            default:   state_d = SYNC_HUNT;
        endcase
    end

    // state register and position counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SYNC_HUNT;
            cnt_q   <= '0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (bit_en) cnt_q <= frame_pulse ? '0 : cnt_q + POS_W'(1);
            if (bit_en && frame_pulse) bank_q <= ~bank_q;
        end
    end

    // outputs
    always_comb begin
        pos  = frame_pulse ? '0 : cnt_q + POS_W'(1);
        bank = (bit_en && frame_pulse) ? ~bank_q : bank_q;
        unique case (state_q)
            SYNC_HUNT: act = bit_en && frame_pulse;
            SYNC_RUN:  act = bit_en && (frame_pulse || cnt_q != LAST_POS);
            default:   act = 1'b0;
        endcase
    end

    assert_pulse_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_pulse) |=> (state_q == SYNC_RUN && cnt_q == '0));

    assert_position_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !frame_pulse && state_q == SYNC_RUN && cnt_q != LAST_POS)
        |=> (cnt_q == $past(cnt_q) + POS_W'(1) && state_q == SYNC_RUN));

    assert_lost_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !frame_pulse && state_q == SYNC_RUN && cnt_q == LAST_POS)
        |=> state_q == SYNC_HUNT);
endmodule

// File: rtl/tsi_capture.sv
module tsi_capture
    import tsi_pkg::*;
(
    input  logic                             clk,
    input  logic                             act,
    input  logic [POS_W-1:0]                 pos,
    input  logic                             bank,
    input  logic [STREAMS-1:0]               ser_in,
    input  logic [STREAMS-1:0][ADDR_W-1:0]   rd_addr,
    output logic [STREAMS-1:0][BYTE_W-1:0]   rd_data
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] store [2][SLOTS];
    logic [BYTE_W-2:0] sh_q  [STREAMS];

    // serial-to-parallel per stream; full byte lands in the frame's bank
    always_ff @(posedge clk) begin
        if (act) begin
            for (int s = 0; s < STREAMS; s++) begin
                if (pos[BIT_W-1:0] == LAST_BIT)
                    store[bank][{STR_W'(s), pos[POS_W-1:BIT_W]}] <= {sh_q[s], ser_in[s]};
                else
                    sh_q[s] <= {sh_q[s][BYTE_W-3:0], ser_in[s]};
            end
        end
    end

    // reads come from the bank filled during the previous frame
    always_comb begin
        for (int s = 0; s < STREAMS; s++)
            rd_data[s] = store[~bank][rd_addr[s]];
    end
endmodule

// File: rtl/tsi_conn_store.sv
module tsi_conn_store
    import tsi_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              waddr,
    input  conn_entry_t                    wentry,
    input  logic [STREAMS-1:0][ADDR_W-1:0] rd_addr,
    output conn_entry_t [STREAMS-1:0]      rd_entry
);
    conn_entry_t table_q [SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < SLOTS; a++) table_q[a] <= '0;
        end else if (we) begin
            table_q[waddr] <= wentry;
        end
    end

    always_comb begin
        for (int s = 0; s < STREAMS; s++)
            rd_entry[s] = table_q[rd_addr[s]];
    end
endmodule

// File: rtl/tsi_emitter.sv
module tsi_emitter
    import tsi_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bit_en,
    input  logic                           act,
    input  logic [POS_W-1:0]               pos,
    input  conn_entry_t [STREAMS-1:0]      entry,
    input  logic [STREAMS-1:0][BYTE_W-1:0] dm_byte,
    output logic [STREAMS-1:0]             ser_out
);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

    logic             first_bit;
    logic [BIT_W-1:0] sel_bit;

    assign first_bit = (pos[BIT_W-1:0] == '0);
    assign sel_bit   = TOP_BIT - pos[BIT_W-1:0];

    for (genvar g = 0; g < STREAMS; g++) begin : g_lane
        logic [BYTE_W-1:0] pick;
        logic [BYTE_W-1:0] hold_q;
        logic              out_q;

        always_comb begin
            if (!entry[g].drive)       pick = '1;
            else if (entry[g].literal) pick = entry[g].value;
            else                       pick = dm_byte[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q <= '1;
                out_q  <= 1'b1;
            end else if (act) begin
                if (first_bit) begin
                    hold_q <= pick;
                    out_q  <= pick[BYTE_W-1];
                end else begin
                    out_q  <= hold_q[sel_bit];
                end
            end else if (bit_en) begin
                out_q <= 1'b1;
            end
        end

        assign ser_out[g] = out_q;

        assert_blank_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (act && first_bit && !entry[g].drive) |=> ser_out[g]);

        assert_literal_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (act && first_bit && entry[g].drive && entry[g].literal)
            |=> ser_out[g] == $past(entry[g].value[BYTE_W-1]));
    end

    assert_quiet_between_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(ser_out));

    assert_unsynced_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_en && !act) |-> ser_out == '1);
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               frame_pulse,
    input  logic [STREAMS-1:0] ser_in,
    output logic [STREAMS-1:0] ser_out,
    input  logic               cm_we,
    input  logic [ADDR_W-1:0]  cm_addr,
    input  logic               cm_drive,
    input  logic               cm_literal,
    input  logic [BYTE_W-1:0]  cm_value
);
    logic                           act;
    logic [POS_W-1:0]               pos;
    logic                           bank;
    logic [STREAMS-1:0][ADDR_W-1:0] conn_addr;
    logic [STREAMS-1:0][ADDR_W-1:0] src_addr;
    conn_entry_t [STREAMS-1:0]      entry;
    logic [STREAMS-1:0][BYTE_W-1:0] dm_byte;
    conn_entry_t                    wentry;

    assign wentry = '{drive: cm_drive, literal: cm_literal, value: cm_value};

    for (genvar g = 0; g < STREAMS; g++) begin : g_addr
        assign conn_addr[g] = {STR_W'(g), pos[POS_W-1:BIT_W]};
        assign src_addr[g]  = entry[g].value[ADDR_W-1:0];
    end

    tsi_frame_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .frame_pulse (frame_pulse),
        .act         (act),
        .pos         (pos),
        .bank        (bank)
    );

    tsi_capture u_capture (
        .clk     (clk),
        .act     (act),
        .pos     (pos),
        .bank    (bank),
        .ser_in  (ser_in),
        .rd_addr (src_addr),
        .rd_data (dm_byte)
    );

    tsi_conn_store u_conn (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cm_we),
        .waddr    (cm_addr),
        .wentry   (wentry),
        .rd_addr  (conn_addr),
        .rd_entry (entry)
    );

    tsi_emitter u_emit (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .act     (act),
        .pos     (pos),
        .entry   (entry),
        .dm_byte (dm_byte),
        .ser_out (ser_out)
    );
endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       frame_pulse = 1'b0;
    logic [7:0] ser_in = '0;
    logic [7:0] ser_out;
    logic       cm_we = 1'b0;
    logic [7:0] cm_addr = '0;
    logic       cm_drive = 1'b0;
    logic       cm_literal = 1'b0;
    logic [7:0] cm_value = '0;

    always #2.5 clk = ~clk;

    tsi_switch u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_pulse(frame_pulse),
        .ser_in(ser_in), .ser_out(ser_out), .cm_we(cm_we), .cm_addr(cm_addr),
        .cm_drive(cm_drive), .cm_literal(cm_literal), .cm_value(cm_value)
    );

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int          drv_frame = 0;
    longint      cyc = 0;

    // ---------------- behavioural reference model ----------------
    int          gfr = 0;
    bit          synced = 0;
    bit          lost = 0;
    bit          resync = 0;
    int          mpos = 0;
    logic [7:0]  acc [8];
    logic [7:0]  got [int];
    logic [9:0]  cm [256];
    longint      wr_t [256];
    longint      latch_t [256];
    logic [7:0]  held [8];
    bit          exp_bit [8];
    bit          known [8];
    string       tag [8];
    bit          strobe_prev = 0;

    initial begin
        for (int a = 0; a < 256; a++) begin cm[a] = '0; wr_t[a] = 0; latch_t[a] = 0; end
        for (int s = 0; s < 8; s++) begin exp_bit[s] = 1; known[s] = 1; tag[s] = "R1"; held[s] = '1; acc[s] = '0; end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            bit go;
            cyc++;
            strobe_prev = bit_en;
            if (bit_en) begin
                go = 0;
                if (frame_pulse) begin
                    resync = synced && (mpos != 255);
                    gfr++; synced = 1; lost = 0; mpos = 0; go = 1;
                end else if (synced) begin
                    if (mpos == 255) begin synced = 0; lost = 1; end
                    else begin mpos++; go = 1; end
                end
                if (!go) begin
                    for (int s = 0; s < 8; s++) begin
                        exp_bit[s] = 1; known[s] = 1; tag[s] = lost ? "R8" : "R1";
                    end
                end else begin
                    int ch; int b;
                    ch = mpos / 8; b = 7 - (mpos % 8);
                    for (int s = 0; s < 8; s++) begin
                        acc[s] = {acc[s][6:0], ser_in[s]};
                        if (b == 0) got[gfr * 256 + s * 32 + ch] = acc[s];
                        if (b == 7) begin
                            int a; logic [9:0] e; int key;
                            a = s * 32 + ch; e = cm[a];
                            if (!e[9]) begin held[s] = 8'hFF; known[s] = 1; tag[s] = "R6"; end
                            else if (e[8]) begin held[s] = e[7:0]; known[s] = 1; tag[s] = "R5"; end
                            else begin
                                key = (gfr - 1) * 256 + int'(e[7:0]);
                                known[s] = got.exists(key);
                                held[s] = known[s] ? got[key] : 8'hFF;
                                tag[s] = resync ? "R9" : "R2/R3/R4";
                            end
                            if (latch_t[a] != 0 && wr_t[a] > latch_t[a]) tag[s] = "R7";
                            latch_t[a] = cyc;
                        end
                        exp_bit[s] = held[s][b];
                    end
                end
            end
            if (cm_we) begin
                cm[cm_addr] = {cm_drive, cm_literal, cm_value};
                wr_t[cm_addr] = cyc;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < 8; s++) begin
                if (known[s]) begin
                    n_cmp++;
                    if (ser_out[s] !== exp_bit[s]) begin
                        n_bad++;
                        $display("FAIL %s%s stream %0d at cycle %0d: got %b expected %b",
                                 tag[s], strobe_prev ? "" : "/R10", s, cyc, ser_out[s], exp_bit[s]);
                    end
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [7:0] pattern(int f, int s, int ch);
        return 8'((f * 29 + s * 47 + ch * 3 + 1) & 255);
    endfunction

    task automatic host_write(input int a, input bit drv, input bit lit, input logic [7:0] v);
        @(negedge clk);
        cm_we = 1; cm_addr = 8'(a); cm_drive = drv; cm_literal = lit; cm_value = v;
        @(negedge clk);
        cm_we = 0;
    endtask

    task automatic drive_frame(input int nbits, input bit pulse, input int wpos,
                               input int waddr, input logic [9:0] wval);
        drv_frame++;
        for (int p = 0; p < nbits; p++) begin
            @(negedge clk);
            bit_en = 1;
            frame_pulse = pulse && (p == 0);
            for (int s = 0; s < 8; s++) ser_in[s] = pattern(drv_frame, s, p / 8)[7 - (p % 8)];
            @(negedge clk);
            bit_en = 0; frame_pulse = 0;
            if (p == wpos) begin
                cm_we = 1; cm_addr = 8'(waddr);
                cm_drive = wval[9]; cm_literal = wval[8]; cm_value = wval[7:0];
            end
            @(negedge clk);
            cm_we = 0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (ser_out !== 8'hFF) begin
            n_bad++; $display("FAIL R1 reset: got %h expected ff", ser_out);
        end
        rst_n = 1;
        drive_frame(30, 0, -1, 0, '0);          // R1: strobes while hunting
        for (int a = 0; a < 256; a++) begin       // R3/R4/R5/R6 connection setup
            int s; int c;
            s = a / 32; c = a % 32;
            if (s != 2) begin
                if (s == 1 || (s == 5 && c % 2 == 1))
                    host_write(a, 1, 1, 8'((a * 7 + 3) & 255));
                else if (s == 3)
                    host_write(a, 1, 0, 8'(a));
                else
                    host_write(a, 1, 0, 8'((a * 13 + 5) & 255));
            end
        end
        drive_frame(256, 1, -1, 0, '0);
        drive_frame(256, 1, -1, 0, '0);
        drive_frame(256, 1, 100, 1 * 32 + 12, {2'b11, 8'h5A});   // R7 mid-channel literal change
        drive_frame(256, 1, 40, 0 * 32 + 5, {2'b10, 8'hE3});     // R7 mid-channel source change
        drive_frame(256, 1, 10, 4 * 32 + 20, {2'b00, 8'h00});    // R7/R6 disable ahead of channel
        drive_frame(150, 1, -1, 0, '0);                          // R9 cut-short frame
        drive_frame(256, 1, -1, 0, '0);
        drive_frame(256, 1, -1, 0, '0);
        drive_frame(20, 0, -1, 0, '0);                           // R8 missing pulse
        drive_frame(256, 1, -1, 0, '0);
        drive_frame(256, 1, -1, 0, '0);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule